// File: doc/BRIEF.md
# Prescaled Event Timer with Access-Triggered Flag Clearing

This block is a 16-bit free-running counter that a host reaches over a small byte-wide register bus. A power-of-two prescaler sets how fast the counter advances. When the counter wraps from its top value to zero, an overflow flag is raised. A single compare channel raises a match flag whenever the counter equals a programmed value. As an option, that match can send the counter back to zero, so the block works as a periodic timebase. Each flag drives its own interrupt request, and each request has its own enable bit.

The host clears a flag by writing a one to its bit. It can also switch on an access-triggered clear mode. In that mode, any read or write of the counter bytes clears the overflow flag, and any write to the compare bytes clears the match flag. The host can disable the counter, or halt it while the chip is in debug or wait state. The counter bytes accept writes only while the special-mode input is high.

Top module: `tmr_fast_clear_timer`

## Requirements
- R1: Register map, 3-bit address. 0 is control A: bit7 run, bit6 halt in wait, bit5 halt in debug, bit4 access-clear. 1 is control B: bit7 overflow irq enable, bit6 match irq enable, bit3 reload on match, bits2:0 divider exponent. 2 and 3 are the counter high and low bytes. 4 and 5 are the compare high and low bytes. 6 is the match flag at bit7. 7 is the overflow flag at bit7. After reset every register reads zero and both irq outputs are low.
- R2: While running, the counter advances by one every 2^e clock cycles, where e is the divider exponent.
- R3: With run cleared the counter holds its value, and the prescaler phase restarts.
- R4: The counter holds while debug_mode is high and the halt-in-debug bit is set. It also holds while wait_mode is high and the halt-in-wait bit is set. If the matching control bit is clear, the counter keeps running.
- R5: The overflow flag sets when a tick takes the counter from 0xFFFF to 0x0000.
- R6: Writing 1 to bit7 of a flag register clears that flag. Writing 0 leaves it unchanged.
- R7: Each irq output is high exactly while its flag and its enable bit are both set.
- R8: With access-clear set, a read or write of either counter byte clears the overflow flag. With access-clear clear, such accesses leave the flag alone.
- R9: With access-clear set, a write to either compare byte clears the match flag. With access-clear clear, such writes leave it alone.
- R10: A counter byte write loads that byte only while special_mode is high. Otherwise the write has no effect on the counter.
- R11: A tick on which the counter equals the compare value sets the match flag. If reload-on-match is set, that tick loads zero instead of incrementing.
- R12: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| debug_mode | input | 1 | Chip is in debug state |
| wait_mode | input | 1 | Chip is in wait state |
| special_mode | input | 1 | Allows counter writes |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare-match interrupt request |

## Verification
The assertions check on every cycle that the counter holds when there is no tick and no load, and that it steps by exactly one on a plain tick. They also check that a match with reload enabled produces zero, that blocked counter writes change nothing, that a flag set always beats a clear, and that an access-triggered clear empties the overflow flag. Only the bench scenarios can show the actual prescale ratios, and that the halt bits depend on the chip-state inputs. The same holds for the exact edge where an overflow lands on a clear write, and for the register map as the host sees it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W    = 3;
  localparam int DIV_SEL_W = 3;

  localparam logic [ADDR_W-1:0] A_CTLA = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTLB = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMPH = 3'd4;
  localparam logic [ADDR_W-1:0] A_CMPL = 3'd5;
  localparam logic [ADDR_W-1:0] A_FLGC = 3'd6;
  localparam logic [ADDR_W-1:0] A_FLGO = 3'd7;

  // flag vector indices
  localparam int F_CMP = 0;
  localparam int F_OVF = 1;
  localparam int N_FLAGS = 2;

  typedef struct packed {
    logic run;
    logic wait_stop;
    logic dbg_freeze;
    logic fast_clr;
  } ctla_t;

  typedef struct packed {
    logic                 ovf_ie;
    logic                 cmp_ie;
    logic                 cmp_reset;
    logic [DIV_SEL_W-1:0] div_sel;
  } ctlb_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             halt,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  function automatic logic [PRE_W-1:0] term_count(input logic [SEL_W-1:0] s);
    term_count = PRE_W'((1 << s) - 1);
  endfunction

  logic [PRE_W-1:0] pcnt;
  logic             active;

  assign active = run & ~halt;
  assign tick   = active && (pcnt >= term_count(div_sel));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcnt <= '0;
    else if (!run)   pcnt <= '0;
    else if (active) pcnt <= tick ? '0 : pcnt + 1'b1;
  end

  // R3: a disabled prescaler never produces a tick
  assert_no_tick_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmp_reset,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [CNT_W-1:0]  cmp_val,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_evt,
  output logic              cmp_evt
);
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic hit, input logic rld);
    next_count = (hit && rld) ? '0 : cur + 1'b1;
  endfunction

  logic loading;
  assign loading = ld_hi | ld_lo;
  assign cmp_evt = tick && (count == cmp_val);
  assign ovf_evt = tick && (&count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (loading) begin
      if (ld_hi) count[CNT_W-1:DATA_W] <= ld_data;
      if (ld_lo) count[DATA_W-1:0]     <= ld_data;
    end else if (tick) count <= next_count(count, cmp_evt, cmp_reset);
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !loading && !(cmp_reset && cmp_evt)) |=> count == $past(count) + CNT_W'(1));

  assert_count_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !loading) |=> $stable(count));

  assert_reload_on_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && cmp_reset && !loading) |=> count == '0);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/tmr_fast_clear_timer.sv
module tmr_fast_clear_timer
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              debug_mode,
  input  logic              wait_mode,
  input  logic              special_mode,
  output logic              ovf_irq,
  output logic              cmp_irq
);
  ctla_t              ctla;
  ctlb_t              ctlb;
  logic [CNT_W-1:0]   cmp_val;
  logic [CNT_W-1:0]   count;
  logic               tick, halt, ovf_evt, cmp_evt;
  logic               cnt_sel, cnt_access, cmp_write;
  logic [N_FLAGS-1:0] flag_set, flag_clr, flags;

  // bus decode, exposed as named events
  assign cnt_sel    = (addr == A_CNTH) || (addr == A_CNTL);
  assign cnt_access = (rd_en | wr_en) && cnt_sel;
  assign cmp_write  = wr_en && ((addr == A_CMPH) || (addr == A_CMPL));
  assign halt       = (debug_mode & ctla.dbg_freeze) | (wait_mode & ctla.wait_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctla    <= '0;
      ctlb    <= '0;
      cmp_val <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTLA: ctla <= ctla_t'(wdata[DATA_W-1 -: 4]);
        A_CTLB: ctlb <= '{ovf_ie: wdata[7], cmp_ie: wdata[6], cmp_reset: wdata[3],
                          div_sel: wdata[DIV_SEL_W-1:0]};
        A_CMPH: cmp_val[CNT_W-1:DATA_W] <= wdata;
        A_CMPL: cmp_val[DATA_W-1:0]     <= wdata;
        default: ;
      endcase
    end
  end

  tmr_prescaler #(.SEL_W(DIV_SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctla.run), .halt(halt),
    .div_sel(ctlb.div_sel), .tick(tick)
  );

  tmr_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmp_reset(ctlb.cmp_reset),
    .ld_hi(wr_en && special_mode && addr == A_CNTH),
    .ld_lo(wr_en && special_mode && addr == A_CNTL),
    .ld_data(wdata), .cmp_val(cmp_val), .count(count),
    .ovf_evt(ovf_evt), .cmp_evt(cmp_evt)
  );

  assign flag_set[F_CMP] = cmp_evt;
  assign flag_set[F_OVF] = ovf_evt;
  assign flag_clr[F_CMP] = (wr_en && addr == A_FLGC && wdata[DATA_W-1]) | (ctla.fast_clr & cmp_write);
  assign flag_clr[F_OVF] = (wr_en && addr == A_FLGO && wdata[DATA_W-1]) | (ctla.fast_clr & cnt_access);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clr[g]), .flag(flags[g])
    );
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTLA: rdata = {ctla, 4'b0};
      A_CTLB: rdata = {ctlb.ovf_ie, ctlb.cmp_ie, 2'b0, ctlb.cmp_reset, ctlb.div_sel};
      A_CNTH: rdata = count[CNT_W-1:DATA_W];
      A_CNTL: rdata = count[DATA_W-1:0];
      A_CMPH: rdata = cmp_val[CNT_W-1:DATA_W];
      A_CMPL: rdata = cmp_val[DATA_W-1:0];
      A_FLGC: rdata = {flags[F_CMP], 7'b0};
      A_FLGO: rdata = {flags[F_OVF], 7'b0};
      default: rdata = '0;
    endcase
  end

  assign ovf_irq = flags[F_OVF] & ctlb.ovf_ie;
  assign cmp_irq = flags[F_CMP] & ctlb.cmp_ie;

  assert_no_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cnt_sel && !special_mode && !tick) |=> $stable(count));

  assert_access_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctla.fast_clr && cnt_access && !ovf_evt) |=> !ovf_irq && (rdata[DATA_W-1] == 1'b0 || addr != A_FLGO));

  assert_wrap_sets_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && ctlb.ovf_ie && !(wr_en && addr == A_CTLB)) |=> ovf_irq);
endmodule

// File: tb/tb_tmr_fast_clear_timer.sv
module tb_tmr_fast_clear_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       debug_mode = 1'b0, wait_mode = 1'b0, special_mode = 1'b0;
  logic       ovf_irq, cmp_irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] va, vb;

  always #5 clk = ~clk;

  tmr_fast_clear_timer dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .debug_mode(debug_mode), .wait_mode(wait_mode),
    .special_mode(special_mode), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic load_count(input logic [15:0] v);
    special_mode = 1'b1;
    wr(3'd2, v[15:8]);
    wr(3'd3, v[7:0]);
    special_mode = 1'b0;
  endtask

  // count advance of low byte over (2 + gap) cycles
  task automatic measure(input int gap, output int delta);
    logic [7:0] a0, a1;
    rd(3'd3, a0);
    repeat (gap) @(negedge clk);
    rd(3'd3, a1);
    delta = int'(8'(a1 - a0));
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 ovf_irq after reset", ovf_irq, 0);
    chk("R1 cmp_irq after reset", cmp_irq, 0);
  endtask

  task automatic t_load();
    wr(3'd3, 8'h55);
    rd(3'd3, va);
    chk("R10 write blocked outside special mode", va, 8'h00);
    load_count(16'h1234);
    rd(3'd2, va); rd(3'd3, vb);
    chk("R10 high byte loaded", va, 8'h12);
    chk("R10 low byte loaded", vb, 8'h34);
  endtask

  task automatic t_prescale();
    int d;
    wr(3'd0, 8'h00); load_count(16'h0000); wr(3'd1, 8'h00); wr(3'd0, 8'h80);
    measure(8, d);  chk("R2 divide by 1", d, 10);
    wr(3'd0, 8'h00); load_count(16'h0000); wr(3'd1, 8'h02); wr(3'd0, 8'h80);
    measure(38, d); chk("R2 divide by 4", d, 10);
    wr(3'd0, 8'h00); load_count(16'h0000); wr(3'd1, 8'h05); wr(3'd0, 8'h80);
    measure(126, d); chk("R2 divide by 32", d, 4);
  endtask

  task automatic t_disable();
    int d;
    wr(3'd0, 8'h00);
    measure(20, d); chk("R3 disabled counter holds", d, 0);
  endtask

  task automatic t_halt();
    int d;
    wr(3'd0, 8'h00); load_count(16'h0000); wr(3'd1, 8'h00);
    debug_mode = 1'b1;
    wr(3'd0, 8'hA0);
    measure(8, d); chk("R4 frozen in debug", d, 0);
    debug_mode = 1'b0;
    measure(8, d); chk("R4 runs after debug exit", d, 10);
    debug_mode = 1'b1; wr(3'd0, 8'h80);
    measure(8, d); chk("R4 debug without freeze bit runs", d, 10);
    debug_mode = 1'b0;
    wait_mode = 1'b1; wr(3'd0, 8'hC0);
    measure(8, d); chk("R4 stopped in wait", d, 0);
    wr(3'd0, 8'h80);
    measure(8, d); chk("R4 wait without stop bit runs", d, 10);
    wait_mode = 1'b0;
  endtask

  task automatic t_overflow();
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd7, 8'h80);
    load_count(16'hFFF0);
    wr(3'd0, 8'h80);
    repeat (30) @(negedge clk);
    rd(3'd7, va); chk("R5 overflow flag set", va, 8'h80);
    chk("R7 irq masked", ovf_irq, 0);
    wr(3'd1, 8'h80);
    #1 chk("R7 irq with enable", ovf_irq, 1);
    wr(3'd7, 8'h00);
    rd(3'd7, va); chk("R6 write zero keeps flag", va, 8'h80);
    wr(3'd7, 8'h80);
    rd(3'd7, va); chk("R6 write one clears flag", va, 8'h00);
    chk("R7 irq drops with flag", ovf_irq, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_access_clear();
    wr(3'd0, 8'h00); load_count(16'hFFFE); wr(3'd0, 8'h80);
    repeat (10) @(negedge clk);
    rd(3'd3, va);
    rd(3'd7, va); chk("R8 counter read without access-clear keeps flag", va, 8'h80);
    wr(3'd0, 8'h90);
    rd(3'd2, va);
    rd(3'd7, va); chk("R8 counter read clears flag", va, 8'h00);
    wr(3'd0, 8'h00); load_count(16'hFFFE); wr(3'd0, 8'h80);
    repeat (10) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd7, va); chk("R5 overflow flag set again", va, 8'h80);
    rd(3'd3, vb);
    wr(3'd0, 8'h10);
    wr(3'd3, 8'h77);
    rd(3'd7, va); chk("R8 counter write clears flag", va, 8'h00);
    rd(3'd3, va); chk("R10 normal-mode write leaves counter", va, vb);
  endtask

  task automatic t_compare();
    int mx;
    logic [7:0] v;
    wr(3'd0, 8'h00); wr(3'd6, 8'h80); load_count(16'h0000);
    wr(3'd4, 8'h00); wr(3'd5, 8'h05);
    wr(3'd1, 8'h48);
    wr(3'd0, 8'h80);
    mx = 0;
    for (int i = 0; i < 12; i++) begin
      rd(3'd3, v);
      if (int'(v) > mx) mx = int'(v);
    end
    chk("R11 reload keeps count at or below compare", (mx <= 5) ? 1 : 0, 1);
    rd(3'd2, v); chk("R11 high byte stays zero", v, 8'h00);
    rd(3'd6, v); chk("R11 match flag set", v, 8'h80);
    chk("R7 compare irq", cmp_irq, 1);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h05);
    rd(3'd6, v); chk("R9 compare write without access-clear keeps flag", v, 8'h80);
    wr(3'd0, 8'h10);
    wr(3'd5, 8'h05);
    rd(3'd6, v); chk("R9 compare write clears flag", v, 8'h00);
    chk("R7 compare irq drops", cmp_irq, 0);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
  endtask

  task automatic t_set_wins();
    wr(3'd0, 8'h00); wr(3'd1, 8'h00); wr(3'd7, 8'h80);
    load_count(16'hFFFE);
    wr(3'd0, 8'h80);   // ticks on the next two edges; wrap on the second
    wr(3'd7, 8'h80);   // clear lands on the wrap edge
    rd(3'd7, va); chk("R12 set beats same-cycle clear", va, 8'h80);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_prescale();
    t_disable();
    t_halt();
    t_overflow();
    t_access_clear();
    t_compare();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule